// File: doc/BRIEF.md
# Reversible Feistel Pseudorandom Byte Generator

This block walks a long pseudorandom byte string one position per strobe, and it can walk the same string backwards. Its state is a pair of 48-bit registers, a left half and a right half. A forward move is one Feistel round: the right half moves into the left, and the old left half is mixed with a one-way function of the old right half. The byte presented at the output folds together the top byte of each half. That byte is unchanged when the halves trade places.

To turn around, the caller issues a flip, which exchanges the halves in one cycle. From there, ordinary moves retrace the earlier states, and the output bytes come back in reverse order. A second flip after retracing restores the exact starting state. A consumer can therefore sweep a long random string forwards and backwards while storing only 96 bits. Seeding reuses the move path. Each load strobe shifts the right half into the left half and takes 48 new bits into the right half, so two loads fill the whole state. Reset is synchronous and clears both halves.

Top module: `rev_prbg`

## Requirements
- R1: While `rst` is high at a clock edge, both halves are cleared, so `rnd_byte` reads 8'h00 after that edge.
- R2: A `seed_load` edge copies the right half into the left half and `seed_data` into the right half. Loading A and then B gives left=A and right=B.
- R3: A move (`step` alone) sets new left = old right and new right = old left XOR F(old right). F(x) = rotl(x,5) ^ (rotl(x,11) & rotl(x,23)) ^ rotl(x,45) ^ 48'h79B97F4A7C15, with rotl a 48-bit left rotation.
- R4: `rnd_byte` always equals left[47:40] XOR right[47:40].
- R5: A flip exchanges the two halves in one cycle, and `rnd_byte` keeps its value across the flip.
- R6: After N moves and then a flip, N further moves reproduce the N bytes seen before the flip, in reverse order.
- R7: A second flip after those N backward moves restores the original state. Moving forward again repeats the original byte sequence.
- R8: Priority is rst, then seed_load, then flip, then step. When `step` and `flip` are high together, only the flip happens.
- R9: With no strobe high, the state and `rnd_byte` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Shift `seed_data` into the right half |
| seed_data | input | 48 | Seed word |
| step | input | 1 | Advance one position (Feistel round) |
| flip | input | 1 | Reverse direction by exchanging halves |
| rnd_byte | output | 8 | Folded output byte of the current state |

## Verification
The properties assume that every strobe and the seed word are known values, never X, at each clock edge once reset is low. They also assume that reset is high at the first edge, because the halves have no value until a reset has cleared them. The bench holds reset high from time zero and changes inputs only on falling edges, so each strobe is stable around the rising edge. Combined strobes are used deliberately, to exercise the priority order instead of avoiding it.

// File: rtl/rev_prbg_pkg.sv
package rev_prbg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_SEED = 2'd1,
    OP_FLIP = 2'd2,
    OP_MOVE = 2'd3
  } prbg_op_e;
endpackage

// File: rtl/rev_prbg_ctrl.sv
module rev_prbg_ctrl
  import rev_prbg_pkg::*;
(
  input  logic     seed_load,
  input  logic     flip,
  input  logic     step,
  output prbg_op_e op
);
  // Fixed priority: seed, then flip, then move.
  always_comb begin
    if (seed_load)  op = OP_SEED;
    else if (flip)  op = OP_FLIP;
    else if (step)  op = OP_MOVE;
    else            op = OP_HOLD;
  end
endmodule

// File: rtl/rev_prbg_mix.sv
module rev_prbg_mix #(
  parameter int HALF_W = 48,
  parameter int ROT_A  = 5,
  parameter int ROT_B  = 11,
  parameter int ROT_C  = 23,
  parameter int ROT_D  = 45
) (
  input  logic [HALF_W-1:0] x,
  output logic [HALF_W-1:0] y
);
  localparam logic [127:0] KSRC = {2{64'h9E3779B97F4A7C15}};
  localparam logic [HALF_W-1:0] KMIX = KSRC[HALF_W-1:0];

  function automatic logic [HALF_W-1:0] rotl(input logic [HALF_W-1:0] v, input int s);
    logic [2*HALF_W-1:0] dbl;
    dbl = {v, v} << s;
    return dbl[2*HALF_W-1:HALF_W];
  endfunction

  function automatic logic [HALF_W-1:0] one_way(input logic [HALF_W-1:0] v);
    return rotl(v, ROT_A) ^ (rotl(v, ROT_B) & rotl(v, ROT_C)) ^ rotl(v, ROT_D) ^ KMIX;
  endfunction

  assign y = one_way(x);
endmodule

// File: rtl/rev_prbg_state.sv
module rev_prbg_state
  import rev_prbg_pkg::*;
#(
  parameter int HALF_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  prbg_op_e          op,
  input  logic [HALF_W-1:0] seed_data,
  input  logic [HALF_W-1:0] mix_out,
  output logic [HALF_W-1:0] left_q,
  output logic [HALF_W-1:0] right_q
);
  logic [HALF_W-1:0] left_d, right_d;

  always_comb begin
    left_d  = left_q;
    right_d = right_q;
    unique case (op)
      OP_SEED: begin left_d = right_q; right_d = seed_data;        end
      OP_FLIP: begin left_d = right_q; right_d = left_q;           end
      OP_MOVE: begin left_d = right_q; right_d = left_q ^ mix_out; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      right_q <= '0;
    end else begin
      left_q  <= left_d;
      right_q <= right_d;
    end
  end

  // R9: idle holds the state
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> ($stable(left_q) && $stable(right_q)));
  // R5: flip exchanges halves
  p_flip_swap_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FLIP) |=> (left_q == $past(right_q) && right_q == $past(left_q)));
  // R3: move shifts right into left and mixes
  p_move_round_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MOVE) |=> (left_q == $past(right_q) && right_q == ($past(left_q) ^ $past(mix_out))));
  // R2: seed shifts in
  p_seed_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SEED) |=> (left_q == $past(right_q) && right_q == $past(seed_data)));
endmodule

// File: rtl/rev_prbg.sv
module rev_prbg
  import rev_prbg_pkg::*;
#(
  parameter int HALF_W = 48,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_load,
  input  logic [HALF_W-1:0] seed_data,
  input  logic              step,
  input  logic              flip,
  output logic [BYTE_W-1:0] rnd_byte
);
  localparam int TOP_LO = HALF_W - BYTE_W;

  prbg_op_e          op;
  logic [HALF_W-1:0] left_q, right_q, mix_out;

  function automatic logic [BYTE_W-1:0] fold(input logic [HALF_W-1:0] a,
                                             input logic [HALF_W-1:0] b);
    return a[HALF_W-1:TOP_LO] ^ b[HALF_W-1:TOP_LO];
  endfunction

  rev_prbg_ctrl u_ctrl (
    .seed_load (seed_load),
    .flip      (flip),
    .step      (step),
    .op        (op)
  );

  rev_prbg_mix #(.HALF_W(HALF_W)) u_mix (
    .x (right_q),
    .y (mix_out)
  );

  rev_prbg_state #(.HALF_W(HALF_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .seed_data (seed_data),
    .mix_out   (mix_out),
    .left_q    (left_q),
    .right_q   (right_q)
  );

  assign rnd_byte = fold(left_q, right_q);

  // R8: step together with flip acts as a flip only
  p_flip_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (flip && step && !seed_load) |=> (left_q == $past(right_q) && right_q == $past(left_q)));
  // R5: output byte unchanged across a flip
  p_flip_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (flip && !seed_load) |=> $stable(rnd_byte));
  // R9: no strobe keeps the output
  p_idle_byte_r9: assert property (@(posedge clk) disable iff (rst)
    (!flip && !step && !seed_load) |=> $stable(rnd_byte));
endmodule

// File: tb/rev_prbg_tb.sv
module rev_prbg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 20;
  localparam logic [47:0] KB = 48'h79B97F4A7C15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seed_load = 1'b0;
  logic [47:0] seed_data = '0;
  logic        step = 1'b0;
  logic        flip = 1'b0;
  logic [7:0]  rnd_byte;

  int total = 0;
  int bad = 0;
  logic [47:0] m_l = '0, m_r = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] fwd[NSTEP+1];

  always #(CLK_PERIOD/2) clk = ~clk;

  rev_prbg u_dut (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_data(seed_data),
    .step(step), .flip(flip), .rnd_byte(rnd_byte)
  );

  function automatic logic [47:0] owf_m(input logic [47:0] x);
    logic [47:0] y;
    for (int i = 0; i < 48; i++)
      y[i] = x[(i+43)%48] ^ (x[(i+37)%48] & x[(i+25)%48]) ^ x[(i+3)%48] ^ KB[i];
    return y;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, update the model, push expectation
  task automatic drive(input logic r, input logic ld, input logic fl, input logic st,
                       input logic [47:0] sd, input string req);
    logic [47:0] t;
    rst = r; seed_load = ld; flip = fl; step = st; seed_data = sd;
    @(posedge clk);
    if (r) begin m_l = '0; m_r = '0; end
    else if (ld) begin m_l = m_r; m_r = sd; end
    else if (fl) begin t = m_l; m_l = m_r; m_r = t; end
    else if (st) begin t = m_r; m_r = m_l ^ owf_m(m_r); m_l = t; end
    exp_q.push_back(m_l[47:40] ^ m_r[47:40]);
    tag_q.push_back(req);
    @(negedge clk);
    rst = 1'b0; seed_load = 1'b0; flip = 1'b0; step = 1'b0;
  endtask

  // monitor: compare each expectation once the design has produced it
  always @(negedge clk) begin
    if (exp_q.size() > 0) check(tag_q.pop_front(), rnd_byte, exp_q.pop_front());
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    drive(1, 0, 0, 0, '0, "R1 reset");
    check("R1 reset byte", rnd_byte, 8'h00);
    // R2 two-cycle seeding
    drive(0, 1, 0, 0, 48'hA5C3_1122_3344, "R2 seed1");
    drive(0, 1, 0, 0, 48'h3C96_5566_7788, "R2 seed2");
    check("R2 seed fold", rnd_byte, 8'hA5 ^ 8'h3C);
    // R9 idle
    for (int k = 0; k < 3; k++) drive(0, 0, 0, 0, 48'hFFFF_FFFF_FFFF, "R9 idle");
    check("R9 idle byte", rnd_byte, 8'hA5 ^ 8'h3C);
    // R3/R4 forward sweep, recorded for R6
    fwd[0] = rnd_byte;
    for (int k = 1; k <= NSTEP; k++) begin
      drive(0, 0, 0, 1, '0, "R3 move");
      fwd[k] = rnd_byte;
    end
    // R5 flip keeps byte
    drive(0, 0, 1, 0, '0, "R5 flip");
    check("R5 byte after flip", rnd_byte, fwd[NSTEP]);
    // R6 backward sweep
    for (int k = NSTEP - 1; k >= 0; k--) begin
      drive(0, 0, 0, 1, '0, "R6 back");
      check("R6 reversed", rnd_byte, fwd[k]);
    end
    // R7 second flip restores, forward repeats
    drive(0, 0, 1, 0, '0, "R7 flip2");
    check("R7 restored byte", rnd_byte, fwd[0]);
    for (int k = 1; k <= NSTEP; k++) begin
      drive(0, 0, 0, 1, '0, "R7 refwd");
      check("R7 repeat", rnd_byte, fwd[k]);
    end
    // R8 priority
    drive(0, 0, 1, 1, '0, "R8 flip+step");
    check("R8 flip wins", rnd_byte, fwd[NSTEP]);
    drive(0, 0, 0, 1, '0, "R8 back after");
    check("R8 back after", rnd_byte, fwd[NSTEP-1]);
    drive(0, 1, 1, 1, 48'h0F00_0000_0001, "R8 seed wins");
    drive(1, 1, 1, 1, 48'h0F00_0000_0001, "R8 reset wins");
    check("R1 reset wins", rnd_byte, 8'h00);
    // R3 moves from the zero state exercise the constant
    for (int k = 0; k < 6; k++) drive(0, 0, 0, 1, '0, "R3 from zero");
    // R4 varied seeds
    drive(0, 1, 0, 0, 48'hFFFF_FFFF_FFFF, "R4 seed a");
    drive(0, 1, 0, 0, 48'h0000_0000_0000, "R4 seed b");
    for (int k = 0; k < 8; k++) drive(0, 0, (k == 4), 1, '0, "R4 mixed");
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule